// File: doc/BRIEF.md
# Ethernet Receive Error Classifier

This block sits at the tail of an Ethernet receive MAC and decides what happened to each incoming frame. It watches the byte stream between a start-of-frame strobe and an end-of-frame strobe, forwards accepted bytes to the receive FIFO, and closes each frame with one of five outcomes: clean, FIFO overrun, no buffer available, non-octet-aligned with a bad check sequence, or aligned with a bad check sequence. The outcome drives per-frame status bits, receive event pulses and three saturating error counters.

After an overrun or an aligned check-sequence failure the receiver drops into hunt mode. In hunt mode every symbol is thrown away until the next start-of-frame strobe. A frame with a trailing dribble nibble has its check sequence judged at the last whole octet. It is flagged only when that check fails, and then it counts as an alignment error rather than a CRC error. When the FIFO is full, an incoming byte is written over the previous one rather than being dropped.

Top module: `eth_rx_err_classify`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_hunt` is 1, all three counters read 0, and `fifo_wr`, `stat_valid`, `evt_rxf` and `evt_bsy` are 0.
- R2: Bytes and end-of-frame strobes that arrive outside a frame, whether in hunt mode or while idle, produce no FIFO write, no status, no event pulse and no counter change. Only `rx_sof` starts a frame.
- R3: Inside a frame that has a buffer (`buf_avail`=1 on the `rx_sof` cycle), each valid byte gives one `fifo_wr` pulse carrying that byte one cycle later. An end of frame with `crc_ok`=1 gives one `stat_valid`+`evt_rxf` pulse, with `stat_ov`, `stat_no` and `stat_cr` all 0, no counter change and `rx_hunt`=0. At most one of the three status error bits is ever set.
- R4: A valid byte that arrives while `fifo_full`=1 is still written, with `fifo_ovw`=1, so that it replaces the previously written byte. `fifo_data` carries the new byte.
- R5: That overrun closes the frame in the same cycle: `stat_valid`, `stat_ov` and `evt_rxf` pulse, the discard counter (select 0) increments and `rx_hunt` becomes 1. The frame's remaining bytes and its end strobe are ignored.
- R6: A frame that starts with `buf_avail`=0 writes nothing to the FIFO. At its end strobe, `evt_bsy` pulses and the discard counter increments. No `stat_valid` or `evt_rxf` is produced, and the receiver returns to idle, not hunt.
- R7: An end of frame with `rx_dribble`=1 and `crc_ok`=0 pulses `stat_valid`, `stat_no` and `evt_rxf` and increments only the alignment counter (select 1), not the CRC counter. The receiver goes to idle.
- R8: An end of frame with `rx_dribble`=1 and `crc_ok`=1 is reported exactly as a clean frame (R3).
- R9: An end of frame with `rx_dribble`=0 and `crc_ok`=0 pulses `stat_valid`, `stat_cr` and `evt_rxf`, increments the CRC counter (select 2) and puts the receiver into hunt mode. No input can disable this check.
- R10: Each counter stops at 2^CNT_W-1 and never wraps. Apart from a clear, it only ever holds its value or steps up by one.
- R11: `cnt_rdata` shows, combinationally, the counter picked by `cnt_sel` (0 discard, 1 alignment, 2 CRC, 3 reads zero). A `cnt_clr` pulse zeroes the selected counter on the next edge and wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Start-of-frame delimiter detected |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | DATA_W | Received byte |
| rx_eof | input | 1 | End-of-frame strobe (not in the same cycle as a byte) |
| rx_dribble | input | 1 | Frame ended with a trailing partial nibble |
| crc_ok | input | 1 | Check sequence good at the last whole octet, sampled with `rx_eof` |
| fifo_full | input | 1 | Receive FIFO has no free entry |
| buf_avail | input | 1 | Receive buffer available, sampled with `rx_sof` |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_ovw | output | 1 | The write replaces the previous entry |
| fifo_data | output | DATA_W | Byte to write |
| stat_valid | output | 1 | Frame closed, status bits valid |
| stat_ov | output | 1 | Overrun status |
| stat_no | output | 1 | Non-octet-aligned status |
| stat_cr | output | 1 | CRC error status |
| evt_rxf | output | 1 | Frame-received event pulse |
| evt_bsy | output | 1 | No-buffer event pulse |
| rx_hunt | output | 1 | Receiver is in hunt mode |
| cnt_sel | input | 2 | Counter select |
| cnt_clr | input | 1 | Clear the selected counter |
| cnt_rdata | output | CNT_W | Selected counter value |

## Verification
The bench goes after the dribble-nibble cases, where a design that looked only at `crc_ok` would flag good dribbled frames or would charge bad ones to the CRC counter instead of the alignment counter. It also drives bytes and a bad end strobe after an overrun, which a design that skipped hunt mode would turn into a second status pulse. Byte writes outside any frame check that idle and hunt both drop traffic. Busy frames are run past the counter's maximum to catch wrap-around, and a clear that lands with an increment checks that the clear wins. The overrun cases check that the full-FIFO byte is still written and marked as an overwrite, not silently lost.

// File: rtl/rxec_pkg.sv
package rxec_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_IDLE = 2'd1,
      ST_RECV = 2'd2,
      ST_DROP = 2'd3
   } rx_state_e;

   localparam int unsigned NUM_CNT   = 3;
   localparam int unsigned CNT_DISC  = 0;
   localparam int unsigned CNT_ALIGN = 1;
   localparam int unsigned CNT_CRC   = 2;
   localparam int unsigned SEL_W     = 2;
endpackage

// File: rtl/rxec_sat_cnt.sv
module rxec_sat_cnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAX = '1;

   initial begin
      assert (W >= 2 && W <= 64) else $error("rxec_sat_cnt: W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (inc && (cnt != MAX)) cnt <= cnt + 1'b1;
   end

   // R10: a full counter stays full unless cleared
   assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == MAX) && !clr) |=> (cnt == MAX));
   // R10: without a clear, only hold or step by one
   assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
   // R11: clear takes effect on the next edge
   assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/rxec_fifo_path.sv
module rxec_fifo_path #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              ovw,
   input  logic [DATA_W-1:0] din,
   output logic              fifo_wr,
   output logic              fifo_ovw,
   output logic [DATA_W-1:0] fifo_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_wr   <= 1'b0;
         fifo_ovw  <= 1'b0;
         fifo_data <= '0;
      end else begin
         fifo_wr  <= acc;
         fifo_ovw <= acc && ovw;
         if (acc) fifo_data <= din;
      end
   end

   // R4: an overwrite is always a real write
   assert_ovw_is_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ovw |-> fifo_wr);
endmodule

// File: rtl/rxec_classify.sv
module rxec_classify
   import rxec_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_sof,
   input  logic               rx_valid,
   input  logic               rx_eof,
   input  logic               rx_dribble,
   input  logic               crc_ok,
   input  logic               fifo_full,
   input  logic               buf_avail,
   output logic               acc,
   output logic               ovw,
   output logic [NUM_CNT-1:0] inc,
   output logic               stat_valid,
   output logic               stat_ov,
   output logic               stat_no,
   output logic               stat_cr,
   output logic               evt_rxf,
   output logic               evt_bsy,
   output logic               rx_hunt
);
   rx_state_e st_q, st_d;
   logic close_d, ov_d, no_d, cr_d, bsy_d;

   always_comb begin
      st_d    = st_q;
      acc     = 1'b0;
      ovw     = 1'b0;
      inc     = '0;
      close_d = 1'b0;
      ov_d    = 1'b0;
      no_d    = 1'b0;
      cr_d    = 1'b0;
      bsy_d   = 1'b0;
      case (st_q)
         ST_HUNT, ST_IDLE: begin
            if (rx_sof) st_d = buf_avail ? ST_RECV : ST_DROP;
         end
         ST_RECV: begin
            if (rx_valid) begin
               acc = 1'b1;
               if (fifo_full) begin
                  ovw           = 1'b1;
                  close_d       = 1'b1;
                  ov_d          = 1'b1;
                  inc[CNT_DISC] = 1'b1;
                  st_d          = ST_HUNT;
               end
            end
            if (rx_eof && !(rx_valid && fifo_full)) begin
               close_d = 1'b1;
               st_d    = ST_IDLE;
               if (!crc_ok) begin
                  if (rx_dribble) begin
                     no_d           = 1'b1;
                     inc[CNT_ALIGN] = 1'b1;
                  end else begin
                     cr_d         = 1'b1;
                     inc[CNT_CRC] = 1'b1;
                     st_d         = ST_HUNT;
                  end
               end
            end
         end
         ST_DROP: begin
            if (rx_eof) begin
               bsy_d         = 1'b1;
               inc[CNT_DISC] = 1'b1;
               st_d          = ST_IDLE;
            end
         end
         default: st_d = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_HUNT;
         stat_valid <= 1'b0;
         stat_ov    <= 1'b0;
         stat_no    <= 1'b0;
         stat_cr    <= 1'b0;
         evt_rxf    <= 1'b0;
         evt_bsy    <= 1'b0;
      end else begin
         st_q       <= st_d;
         stat_valid <= close_d;
         stat_ov    <= ov_d;
         stat_no    <= no_d;
         stat_cr    <= cr_d;
         evt_rxf    <= close_d;
         evt_bsy    <= bsy_d;
      end
   end

   assign rx_hunt = (st_q == ST_HUNT);

   // R3: status error bits are exclusive and only come with a close
   assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stat_ov, stat_no, stat_cr}) && ((stat_ov || stat_no || stat_cr) -> stat_valid));
   // R5: overrun leaves the receiver hunting
   assert_ovr_hunt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_ov) |-> rx_hunt);
   // R9: aligned CRC failure leaves the receiver hunting
   assert_crc_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_cr) |-> rx_hunt);
   // R7: alignment error does not enter hunt mode
   assert_align_nohunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_no) |-> !rx_hunt);
   // R6: busy discard closes no buffer and does not hunt
   assert_bsy_nostat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_bsy |-> (!stat_valid && !evt_rxf && !rx_hunt));
endmodule

// File: rtl/eth_rx_err_classify.sv
module eth_rx_err_classify
   import rxec_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_sof,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_eof,
   input  logic              rx_dribble,
   input  logic              crc_ok,
   input  logic              fifo_full,
   input  logic              buf_avail,
   output logic              fifo_wr,
   output logic              fifo_ovw,
   output logic [DATA_W-1:0] fifo_data,
   output logic              stat_valid,
   output logic              stat_ov,
   output logic              stat_no,
   output logic              stat_cr,
   output logic              evt_rxf,
   output logic              evt_bsy,
   output logic              rx_hunt,
   input  logic [SEL_W-1:0]  cnt_sel,
   input  logic              cnt_clr,
   output logic [CNT_W-1:0]  cnt_rdata
);
   initial begin
      assert (DATA_W >= 4 && DATA_W <= 64) else $error("eth_rx_err_classify: DATA_W out of range");
      assert (CNT_W >= 2 && CNT_W <= 64) else $error("eth_rx_err_classify: CNT_W out of range");
   end

   logic               acc, ovw;
   logic [NUM_CNT-1:0] inc;
   logic [CNT_W-1:0]   cnt_q [NUM_CNT];

   rxec_classify u_cls (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_sof     (rx_sof),
      .rx_valid   (rx_valid),
      .rx_eof     (rx_eof),
      .rx_dribble (rx_dribble),
      .crc_ok     (crc_ok),
      .fifo_full  (fifo_full),
      .buf_avail  (buf_avail),
      .acc        (acc),
      .ovw        (ovw),
      .inc        (inc),
      .stat_valid (stat_valid),
      .stat_ov    (stat_ov),
      .stat_no    (stat_no),
      .stat_cr    (stat_cr),
      .evt_rxf    (evt_rxf),
      .evt_bsy    (evt_bsy),
      .rx_hunt    (rx_hunt)
   );

   rxec_fifo_path #(.DATA_W(DATA_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .ovw       (ovw),
      .din       (rx_data),
      .fifo_wr   (fifo_wr),
      .fifo_ovw  (fifo_ovw),
      .fifo_data (fifo_data)
   );

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic clr_k;
      assign clr_k = cnt_clr && (cnt_sel == SEL_W'(k));
      rxec_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc[k]),
         .clr   (clr_k),
         .cnt   (cnt_q[k])
      );
   end

   always_comb begin
      cnt_rdata = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (cnt_sel == SEL_W'(k)) cnt_rdata = cnt_q[k];
      end
   end

   // R2: no FIFO write while hunting unless a frame just started
   assert_hunt_nowr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_hunt && !rx_sof) |=> !fifo_wr);
endmodule

// File: tb/eth_rx_err_classify_bench.sv
`timescale 1ns/1ps
module eth_rx_err_classify_bench;
   localparam int DW = 8;
   localparam int CW = 4;
   localparam logic [CW-1:0] CMAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_sof = 0, rx_valid = 0, rx_eof = 0, rx_dribble = 0, crc_ok = 1;
   logic fifo_full = 0, buf_avail = 1, cnt_clr = 0;
   logic [DW-1:0] rx_data = '0;
   logic [1:0]    cnt_sel = '0;
   logic fifo_wr, fifo_ovw, stat_valid, stat_ov, stat_no, stat_cr, evt_rxf, evt_bsy, rx_hunt;
   logic [DW-1:0] fifo_data;
   logic [CW-1:0] cnt_rdata;

   always #2 clk = ~clk;

   eth_rx_err_classify #(.DATA_W(DW), .CNT_W(CW)) u_eth_rx_err_classify (
      .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_eof(rx_eof), .rx_dribble(rx_dribble), .crc_ok(crc_ok), .fifo_full(fifo_full),
      .buf_avail(buf_avail), .fifo_wr(fifo_wr), .fifo_ovw(fifo_ovw), .fifo_data(fifo_data),
      .stat_valid(stat_valid), .stat_ov(stat_ov), .stat_no(stat_no), .stat_cr(stat_cr),
      .evt_rxf(evt_rxf), .evt_bsy(evt_bsy), .rx_hunt(rx_hunt), .cnt_sel(cnt_sel),
      .cnt_clr(cnt_clr), .cnt_rdata(cnt_rdata));

   int checks = 0, errors = 0;
   int n_wr, n_ovw, n_stat, n_rxf, n_bsy;
   logic [DW-1:0] ovw_data;
   logic g_ov, g_no, g_cr;
   int exp_cnt [3];

   always @(negedge clk) begin
      if (fifo_wr) begin
         n_wr++;
         if (fifo_ovw) begin n_ovw++; ovw_data = fifo_data; end
      end
      if (stat_valid) begin n_stat++; g_ov = stat_ov; g_no = stat_no; g_cr = stat_cr; end
      if (evt_rxf) n_rxf++;
      if (evt_bsy) n_bsy++;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic clr_mon();
      n_wr = 0; n_ovw = 0; n_stat = 0; n_rxf = 0; n_bsy = 0;
      g_ov = 0; g_no = 0; g_cr = 0; ovw_data = '0;
   endtask

   task automatic check_counters(input string tag);
      for (int k = 0; k < 3; k++) begin
         cnt_sel = 2'(k);
         #0.1;
         check(int'(cnt_rdata) == exp_cnt[k], tag, int'(cnt_rdata), exp_cnt[k]);
      end
      cnt_sel = 2'd0;
   endtask

   function automatic int bump(input int v);
      return (v < int'(CMAX)) ? v + 1 : v;
   endfunction

   typedef struct packed {
      logic       bav, drib, crc;
      logic [3:0] ovr, nb;
      logic       e_stat, e_ov, e_no, e_cr, e_bsy, e_hunt;
   } vec_t;

   // bav drib crc ovr nb | stat ov no cr bsy hunt
   localparam vec_t VEC [8] = '{
      '{1'b1,1'b0,1'b1,4'd15,4'd4, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},  // R3 clean
      '{1'b1,1'b0,1'b0,4'd15,4'd3, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b1},  // R9 aligned bad
      '{1'b1,1'b1,1'b0,4'd15,4'd5, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0},  // R7 dribble bad
      '{1'b1,1'b1,1'b1,4'd15,4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},  // R8 dribble good
      '{1'b1,1'b0,1'b1,4'd2, 4'd5, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},  // R4 R5 overrun
      '{1'b0,1'b0,1'b1,4'd15,4'd3, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0},  // R6 busy
      '{1'b1,1'b0,1'b1,4'd15,4'd3, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},  // R3 clean
      '{1'b1,1'b1,1'b0,4'd0, 4'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1}   // R5 overrun, bad tail ignored
   };

   task automatic run_frame(input vec_t v, input bit clr_at_eof);
      clr_mon();
      @(negedge clk); rx_sof = 1; buf_avail = v.bav;
      @(negedge clk); rx_sof = 0; buf_avail = 1;
      for (int i = 0; i < int'(v.nb); i++) begin
         rx_valid = 1; rx_data = 8'hA0 + 8'(i); fifo_full = (i == int'(v.ovr));
         @(negedge clk);
      end
      rx_valid = 0; fifo_full = 0;
      rx_eof = 1; rx_dribble = v.drib; crc_ok = v.crc;
      if (clr_at_eof) begin cnt_sel = 2'd0; cnt_clr = 1; end
      @(negedge clk);
      rx_eof = 0; rx_dribble = 0; crc_ok = 1; cnt_clr = 0;
      @(negedge clk);
   endtask

   task automatic stray_bytes();
      clr_mon();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); rx_valid = 1; rx_data = 8'h55; fifo_full = (i == 1);
      end
      @(negedge clk); rx_valid = 0; fifo_full = 0; rx_eof = 1; crc_ok = 0;
      @(negedge clk); rx_eof = 0; crc_ok = 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 3; k++) exp_cnt[k] = 0;
      clr_mon();
      repeat (3) @(negedge clk);
      check(rx_hunt == 1'b1, "R1 hunt in reset", int'(rx_hunt), 1);
      rst_n = 1;
      @(negedge clk); @(negedge clk);
      check(rx_hunt == 1'b1, "R1 hunt after reset", int'(rx_hunt), 1);
      check(n_wr + n_stat + n_rxf + n_bsy == 0, "R1 no pulses", n_wr + n_stat + n_rxf + n_bsy, 0);
      check_counters("R1 counter reset");

      // R2: traffic without a start strobe in hunt mode
      stray_bytes();
      check(n_wr == 0 && n_stat == 0 && n_bsy == 0, "R2 hunt drops", n_wr + n_stat + n_bsy, 0);
      check_counters("R2 counters after hunt traffic");

      foreach (VEC[r]) begin
         vec_t v;
         int ew;
         v = VEC[r];
         run_frame(v, 1'b0);
         ew = v.bav ? ((v.ovr != 4'd15) ? int'(v.ovr) + 1 : int'(v.nb)) : 0;
         if (v.e_ov || v.e_bsy) exp_cnt[0] = bump(exp_cnt[0]);
         if (v.e_no) exp_cnt[1] = bump(exp_cnt[1]);
         if (v.e_cr) exp_cnt[2] = bump(exp_cnt[2]);
         check(n_stat == int'(v.e_stat), $sformatf("R3 row%0d status count", r), n_stat, int'(v.e_stat));
         check({g_ov, g_no, g_cr} == {v.e_ov, v.e_no, v.e_cr},
               $sformatf("R7 R9 row%0d status bits", r), int'({g_ov, g_no, g_cr}), int'({v.e_ov, v.e_no, v.e_cr}));
         check(n_rxf == int'(v.e_stat), $sformatf("R3 row%0d rxf", r), n_rxf, int'(v.e_stat));
         check(n_bsy == int'(v.e_bsy), $sformatf("R6 row%0d bsy", r), n_bsy, int'(v.e_bsy));
         check(rx_hunt == v.e_hunt, $sformatf("R5 R9 row%0d hunt", r), int'(rx_hunt), int'(v.e_hunt));
         check(n_wr == ew, $sformatf("R3 R6 row%0d fifo writes", r), n_wr, ew);
         check(n_ovw == int'(v.e_ov), $sformatf("R4 row%0d overwrite count", r), n_ovw, int'(v.e_ov));
         if (v.e_ov)
            check(ovw_data == 8'hA0 + 8'(v.ovr), $sformatf("R4 row%0d overwrite data", r),
                  int'(ovw_data), int'(8'hA0 + 8'(v.ovr)));
         check_counters($sformatf("R5 R6 R7 R9 row%0d counters", r));
      end

      // R2: traffic without a start strobe while idle
      run_frame(VEC[0], 1'b0);
      check(rx_hunt == 1'b0, "R2 idle after clean", int'(rx_hunt), 0);
      stray_bytes();
      check(n_wr == 0 && n_stat == 0 && n_bsy == 0, "R2 idle drops", n_wr + n_stat + n_bsy, 0);
      check_counters("R2 counters after idle traffic");

      // R10: saturate discard counter with busy frames
      for (int i = 0; i < 14; i++) begin
         run_frame(VEC[5], 1'b0);
         exp_cnt[0] = bump(exp_cnt[0]);
      end
      check(exp_cnt[0] == int'(CMAX), "R10 bench reached max", exp_cnt[0], int'(CMAX));
      check_counters("R10 saturated");

      // R11: clear coinciding with an increment wins
      run_frame(VEC[5], 1'b1);
      exp_cnt[0] = 0;
      check(n_bsy == 1, "R11 busy seen during clear", n_bsy, 1);
      check_counters("R11 clear wins");

      // R11: plain clear of alignment counter, select 3 reads zero
      @(negedge clk); cnt_sel = 2'd1; cnt_clr = 1;
      @(negedge clk); cnt_clr = 0;
      exp_cnt[1] = 0;
      check_counters("R11 clear align");
      cnt_sel = 2'd3; #0.1;
      check(cnt_rdata == '0, "R11 select 3", int'(cnt_rdata), 0);
      cnt_sel = 2'd0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule